// File: doc/BRIEF.md
# DMA Ring Control Register File

This block is the software-visible control plane of a single-channel memory-copy DMA engine. It holds the base address, entry count and two ring indices for a transmit ring and a receive ring. Software owns one of the indices, the CPU index. The engine owns the other, the DMA index, and moves it forward through dedicated hardware inputs. The block also holds a global configuration word, a delayed-interrupt setting word, a sticky interrupt status word and an interrupt mask. Its outputs drive the descriptor fetch engine, which sits outside this block.

Software talks to the block over a plain 32-bit bus with a 12-bit byte address. A write takes effect at the clock edge. Read data is combinational from the address. Software restarts a ring by writing its bit in the ring reset word, which returns that ring's DMA index to zero. The engine reports transfer completions and delayed-interrupt events as single-cycle pulses. Those pulses set status bits, and the interrupt output rises whenever a set status bit is also enabled in the mask.

Top module: `dma_ring_regs`

## Requirements
- R1: After reset, every storage register reads 0, all engine-facing outputs are 0 and `irq_o` is low.
- R2: TX base, count and CPU index sit at 0x000, 0x004 and 0x008. The RX copies sit at 0x100, 0x104 and 0x108. Base is 32 bits wide. Count keeps CNT_W bits and CPU index keeps IDX_W bits, and any bits above those widths read as 0.
- R3: The DMA index at 0x00C (TX) or 0x10C (RX) is read-only, and bus writes to it leave its value unchanged.
- R4: An advance pulse adds one to that ring's DMA index. The index wraps to 0 when the incremented value reaches the ring count. With a count of 0, the index stays at 0.
- R5: Writing to 0x208 with bit 0 set clears the TX DMA index on that edge, and bit 16 does the same for RX. This clear overrides an advance in the same cycle. Address 0x208 always reads 0.
- R6: Configuration word 0x204 has these writable fields: bit 0 TX enable, bit 2 RX enable, bits 5:4 burst code (0=16, 1=32, 2=64, 3=128 bytes) and bit 10 multi-request. All other bits are not stored, and each field drives its own output.
- R7: Bits 1 and 3 of 0x204 read as the TX and RX busy inputs ANDed with the matching enable bit. Bus writes to these two bits have no effect.
- R8: Status word 0x220 is sticky. A TX done pulse sets bit 0, an RX done pulse sets bit 16, and delayed-event pulses 3:0 set bits 31:28.
- R9: Writing 1 to a status bit clears it. A hardware set in the same cycle wins over that clear.
- R10: Mask word 0x228 is a 32-bit read/write register. `irq_o` is high exactly when some status bit and the same mask bit are both 1.
- R11: Info word 0x200 reads RX ring count (NUM_RX) in bits 15:8 and TX ring count (NUM_TX) in bits 7:0. Writes to it have no effect.
- R12: Delayed-interrupt word 0x20C is a 32-bit read/write register and drives `dly_cfg_o`.
- R13: Any address not listed above reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| tx_adv_i | input | 1 | Engine advances the TX DMA index |
| rx_adv_i | input | 1 | Engine advances the RX DMA index |
| tx_busy_i | input | 1 | TX engine active |
| rx_busy_i | input | 1 | RX engine active |
| tx_done_i | input | 1 | TX completion pulse |
| rx_done_i | input | 1 | RX completion pulse |
| dly_evt_i | input | 4 | Delayed-interrupt event pulses |
| tx_base_o | output | 32 | TX ring base |
| tx_cnt_o | output | CNT_W | TX ring entry count |
| tx_cpu_idx_o | output | IDX_W | TX CPU index |
| tx_dma_idx_o | output | IDX_W | TX DMA index |
| rx_base_o | output | 32 | RX ring base |
| rx_cnt_o | output | CNT_W | RX ring entry count |
| rx_cpu_idx_o | output | IDX_W | RX CPU index |
| rx_dma_idx_o | output | IDX_W | RX DMA index |
| tx_en_o | output | 1 | TX enable |
| rx_en_o | output | 1 | RX enable |
| burst_o | output | 2 | Burst size code |
| multi_o | output | 1 | Multi-request enable |
| dly_cfg_o | output | 32 | Delayed-interrupt setting |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: CNT_W and IDX_W of 12, and one TX and one RX ring. With 12-bit widths, a write of a wide value to a count register shows that the upper bits are masked. With one ring of each kind, the info word has a known value of 0x0101. The TX ring count is set to 5, so the wrap point is reached within a few advance pulses. An RX count of 0 covers the degenerate ring that must never move. The bench also drives collisions in a single cycle, such as a ring clear together with an advance and a status clear together with a set.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_BASE = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_CPU  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_DMA  = 12'h00C;
  localparam logic [ADDR_W-1:0] RX_BLK   = 12'h100;

  localparam logic [ADDR_W-1:0] OFF_INFO = 12'h200;
  localparam logic [ADDR_W-1:0] OFF_CFG  = 12'h204;
  localparam logic [ADDR_W-1:0] OFF_RST  = 12'h208;
  localparam logic [ADDR_W-1:0] OFF_DLY  = 12'h20C;
  localparam logic [ADDR_W-1:0] OFF_STAT = 12'h220;
  localparam logic [ADDR_W-1:0] OFF_MASK = 12'h228;

  localparam int CH_ID       = 0;
  localparam int RST_TX_BIT  = 0 + CH_ID;
  localparam int RST_RX_BIT  = 16 + CH_ID;
  localparam int ST_TX_BIT   = 0;
  localparam int ST_RX_BIT   = 16;
  localparam int ST_DLY_LO   = 28;
  localparam int DLY_EVT_N   = 4;

  typedef enum logic {RING_TX = 1'b0, RING_RX = 1'b1} ring_e;

  typedef struct packed {
    logic       multi;
    logic [1:0] burst;
    logic       rx_en;
    logic       tx_en;
  } glb_cfg_t;

  function automatic logic [31:0] stat_impl_mask();
    logic [31:0] m;
    m = '0;
    m[ST_TX_BIT] = 1'b1;
    m[ST_RX_BIT] = 1'b1;
    for (int i = 0; i < DLY_EVT_N; i++) m[ST_DLY_LO+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dma_ring_chan.sv
module dma_ring_chan #(
  parameter int CNT_W = 12,
  parameter int IDX_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      wdata_i,
  input  logic             wr_base_i,
  input  logic             wr_cnt_i,
  input  logic             wr_cpu_i,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [31:0]      base_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [IDX_W-1:0] cpu_idx_o,
  output logic [IDX_W-1:0] dma_idx_o
);
  localparam int CW = ((IDX_W > CNT_W) ? IDX_W : CNT_W) + 1;

  logic [31:0]      base_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] cpu_q, dma_q, dma_d;
  logic [CW-1:0]    inc_w, cnt_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      cpu_q  <= '0;
    end else begin
      if (wr_base_i) base_q <= wdata_i;
      if (wr_cnt_i)  cnt_q  <= wdata_i[CNT_W-1:0];
      if (wr_cpu_i)  cpu_q  <= wdata_i[IDX_W-1:0];
    end
  end

  assign inc_w = CW'(dma_q) + CW'(1);
  assign cnt_w = CW'(cnt_q);

  // clear beats advance; wrap when the increment reaches the count
  always_comb begin
    dma_d = dma_q;
    if (clr_i)          dma_d = '0;
    else if (adv_i) begin
      if (inc_w >= cnt_w) dma_d = '0;
      else                dma_d = inc_w[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dma_q <= '0;
    else         dma_q <= dma_d;
  end

  assign base_o    = base_q;
  assign cnt_o     = cnt_q;
  assign cpu_idx_o = cpu_q;
  assign dma_idx_o = dma_q;

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> dma_idx_o == '0); // R5
  AST_DMA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !adv_i) |=> $stable(dma_idx_o)); // R3
  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && !wr_cnt_i && cnt_o != '0) |=> CW'(dma_idx_o) < CW'(cnt_o)); // R4
  AST_ZERO_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && !wr_cnt_i && cnt_o == '0) |=> dma_idx_o == '0); // R4
endmodule

// File: rtl/dma_ring_glb.sv
module dma_ring_glb
  import dma_ring_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] wdata_i,
  input  logic        wr_cfg_i,
  input  logic        wr_dly_i,
  input  logic        wr_mask_i,
  output glb_cfg_t    cfg_o,
  output logic [31:0] dly_o,
  output logic [31:0] mask_o
);
  glb_cfg_t    cfg_q;
  logic [31:0] dly_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      dly_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_cfg_i) begin
        cfg_q.tx_en <= wdata_i[0];
        cfg_q.rx_en <= wdata_i[2];
        cfg_q.burst <= wdata_i[5:4];
        cfg_q.multi <= wdata_i[10];
      end
      if (wr_dly_i)  dly_q  <= wdata_i;
      if (wr_mask_i) mask_q <= wdata_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign dly_o  = dly_q;
  assign mask_o = mask_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cfg_i |=> $stable(cfg_o)); // R6
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask_i |=> $stable(mask_o)); // R10
endmodule

// File: rtl/dma_ring_irq.sv
module dma_ring_irq
  import dma_ring_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [31:0]          wdata_i,
  input  logic                 wr_stat_i,
  input  logic                 tx_done_i,
  input  logic                 rx_done_i,
  input  logic [DLY_EVT_N-1:0] dly_evt_i,
  input  logic [31:0]          mask_i,
  output logic [31:0]          status_o,
  output logic                 irq_o
);
  localparam logic [31:0] IMPL = stat_impl_mask();

  logic [31:0] stat_q, set_v, clr_v;

  always_comb begin
    set_v = '0;
    set_v[ST_TX_BIT] = tx_done_i;
    set_v[ST_RX_BIT] = rx_done_i;
    set_v[ST_DLY_LO +: DLY_EVT_N] = dly_evt_i;
  end

  assign clr_v = wr_stat_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= ((stat_q & ~clr_v) | set_v) & IMPL;
  end

  assign status_o = stat_q;
  assign irq_o    = |(stat_q & mask_i);

  AST_TX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |=> status_o[ST_TX_BIT]); // R8
  AST_RX_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i |=> status_o[ST_RX_BIT]); // R9
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat_i && wdata_i[ST_TX_BIT] && !tx_done_i) |=> !status_o[ST_TX_BIT]); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_o); // R10
endmodule

// File: rtl/dma_ring_regs.sv
module dma_ring_regs
  import dma_ring_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int IDX_W  = 12,
  parameter int NUM_TX = 1,
  parameter int NUM_RX = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  input  logic                 tx_adv_i,
  input  logic                 rx_adv_i,
  input  logic                 tx_busy_i,
  input  logic                 rx_busy_i,
  input  logic                 tx_done_i,
  input  logic                 rx_done_i,
  input  logic [DLY_EVT_N-1:0] dly_evt_i,
  output logic [31:0]          tx_base_o,
  output logic [CNT_W-1:0]     tx_cnt_o,
  output logic [IDX_W-1:0]     tx_cpu_idx_o,
  output logic [IDX_W-1:0]     tx_dma_idx_o,
  output logic [31:0]          rx_base_o,
  output logic [CNT_W-1:0]     rx_cnt_o,
  output logic [IDX_W-1:0]     rx_cpu_idx_o,
  output logic [IDX_W-1:0]     rx_dma_idx_o,
  output logic                 tx_en_o,
  output logic                 rx_en_o,
  output logic [1:0]           burst_o,
  output logic                 multi_o,
  output logic [31:0]          dly_cfg_o,
  output logic                 irq_o
);
  localparam int N_RING = 2;
  localparam logic [31:0] INFO_VAL = {16'b0, 8'(NUM_RX), 8'(NUM_TX)};

  logic [31:0]      base_a [N_RING];
  logic [CNT_W-1:0] cnt_a  [N_RING];
  logic [IDX_W-1:0] cpu_a  [N_RING];
  logic [IDX_W-1:0] dma_a  [N_RING];
  logic [N_RING-1:0] clr_v, adv_v;

  glb_cfg_t    cfg;
  logic [31:0] dly, mask, status;
  logic        rst_wr, tx_busy_eff, rx_busy_eff;

  assign rst_wr = bus_we_i && (bus_addr_i == OFF_RST);
  assign clr_v[RING_TX] = rst_wr && bus_wdata_i[RST_TX_BIT];
  assign clr_v[RING_RX] = rst_wr && bus_wdata_i[RST_RX_BIT];
  assign adv_v[RING_TX] = tx_adv_i;
  assign adv_v[RING_RX] = rx_adv_i;

  for (genvar g = 0; g < N_RING; g++) begin : g_ring
    localparam logic [ADDR_W-1:0] BLK = (g == int'(RING_RX)) ? RX_BLK : '0;
    dma_ring_chan #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wdata_i   (bus_wdata_i),
      .wr_base_i (bus_we_i && bus_addr_i == (BLK | OFF_BASE)),
      .wr_cnt_i  (bus_we_i && bus_addr_i == (BLK | OFF_CNT)),
      .wr_cpu_i  (bus_we_i && bus_addr_i == (BLK | OFF_CPU)),
      .clr_i     (clr_v[g]),
      .adv_i     (adv_v[g]),
      .base_o    (base_a[g]),
      .cnt_o     (cnt_a[g]),
      .cpu_idx_o (cpu_a[g]),
      .dma_idx_o (dma_a[g])
    );
  end

  dma_ring_glb u_glb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wdata_i   (bus_wdata_i),
    .wr_cfg_i  (bus_we_i && bus_addr_i == OFF_CFG),
    .wr_dly_i  (bus_we_i && bus_addr_i == OFF_DLY),
    .wr_mask_i (bus_we_i && bus_addr_i == OFF_MASK),
    .cfg_o     (cfg),
    .dly_o     (dly),
    .mask_o    (mask)
  );

  dma_ring_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wdata_i   (bus_wdata_i),
    .wr_stat_i (bus_we_i && bus_addr_i == OFF_STAT),
    .tx_done_i (tx_done_i),
    .rx_done_i (rx_done_i),
    .dly_evt_i (dly_evt_i),
    .mask_i    (mask),
    .status_o  (status),
    .irq_o     (irq_o)
  );

  assign tx_busy_eff = tx_busy_i && cfg.tx_en;
  assign rx_busy_eff = rx_busy_i && cfg.rx_en;

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFF_BASE:          bus_rdata_o = base_a[RING_TX];
      OFF_CNT:           bus_rdata_o = 32'(cnt_a[RING_TX]);
      OFF_CPU:           bus_rdata_o = 32'(cpu_a[RING_TX]);
      OFF_DMA:           bus_rdata_o = 32'(dma_a[RING_TX]);
      RX_BLK | OFF_BASE: bus_rdata_o = base_a[RING_RX];
      RX_BLK | OFF_CNT:  bus_rdata_o = 32'(cnt_a[RING_RX]);
      RX_BLK | OFF_CPU:  bus_rdata_o = 32'(cpu_a[RING_RX]);
      RX_BLK | OFF_DMA:  bus_rdata_o = 32'(dma_a[RING_RX]);
      OFF_INFO:          bus_rdata_o = INFO_VAL;
      OFF_CFG:           bus_rdata_o = {21'b0, cfg.multi, 4'b0, cfg.burst,
                                        rx_busy_eff, cfg.rx_en, tx_busy_eff, cfg.tx_en};
      OFF_DLY:           bus_rdata_o = dly;
      OFF_STAT:          bus_rdata_o = status;
      OFF_MASK:          bus_rdata_o = mask;
      default:           bus_rdata_o = '0;
    endcase
  end

  assign tx_base_o    = base_a[RING_TX];
  assign tx_cnt_o     = cnt_a[RING_TX];
  assign tx_cpu_idx_o = cpu_a[RING_TX];
  assign tx_dma_idx_o = dma_a[RING_TX];
  assign rx_base_o    = base_a[RING_RX];
  assign rx_cnt_o     = cnt_a[RING_RX];
  assign rx_cpu_idx_o = cpu_a[RING_RX];
  assign rx_dma_idx_o = dma_a[RING_RX];
  assign tx_en_o      = cfg.tx_en;
  assign rx_en_o      = cfg.rx_en;
  assign burst_o      = cfg.burst;
  assign multi_o      = cfg.multi;
  assign dly_cfg_o    = dly;

  AST_TX_BUSY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == OFF_CFG && !tx_en_o) |-> !bus_rdata_o[1]); // R7
  AST_RX_BUSY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == OFF_CFG && !rx_en_o) |-> !bus_rdata_o[3]); // R7
  AST_RST_CFG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == OFF_RST) |-> bus_rdata_o == '0); // R5
  AST_INFO_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == OFF_INFO) |-> bus_rdata_o[15:0] == {8'(NUM_RX), 8'(NUM_TX)}); // R11
endmodule

// File: tb/dma_ring_regs_tb_top.sv
`timescale 1ns/1ps
module dma_ring_regs_tb_top;
  localparam int CNT_W = 12;
  localparam int IDX_W = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic tx_adv = 0, rx_adv = 0, tx_busy = 0, rx_busy = 0, tx_done = 0, rx_done = 0;
  logic [3:0] dly_evt = '0;
  logic [31:0] tx_base, rx_base, dly_cfg;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [IDX_W-1:0] tx_cpu, tx_dma, rx_cpu, rx_dma;
  logic tx_en, rx_en, multi, irq;
  logic [1:0] burst;

  dma_ring_regs #(.CNT_W(CNT_W), .IDX_W(IDX_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_adv_i(tx_adv), .rx_adv_i(rx_adv), .tx_busy_i(tx_busy), .rx_busy_i(rx_busy),
    .tx_done_i(tx_done), .rx_done_i(rx_done), .dly_evt_i(dly_evt),
    .tx_base_o(tx_base), .tx_cnt_o(tx_cnt), .tx_cpu_idx_o(tx_cpu), .tx_dma_idx_o(tx_dma),
    .rx_base_o(rx_base), .rx_cnt_o(rx_cnt), .rx_cpu_idx_o(rx_cpu), .rx_dma_idx_o(rx_dma),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .burst_o(burst), .multi_o(multi),
    .dly_cfg_o(dly_cfg), .irq_o(irq)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #0.5;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse_tx_adv();
    @(negedge clk); tx_adv = 1'b1;
    @(negedge clk); tx_adv = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 12'h000, 32'hDEADBEEF, 32'h0, 4'd2},
    '{1'b0, 12'h000, 32'h0, 32'hDEADBEEF, 4'd2},          // R2
    '{1'b1, 12'h004, 32'hFFFFF005, 32'h0, 4'd2},
    '{1'b0, 12'h004, 32'h0, 32'h00000005, 4'd2},          // R2 width mask
    '{1'b1, 12'h008, 32'h00000003, 32'h0, 4'd2},
    '{1'b0, 12'h008, 32'h0, 32'h00000003, 4'd2},          // R2
    '{1'b1, 12'h00C, 32'h00000007, 32'h0, 4'd3},
    '{1'b0, 12'h00C, 32'h0, 32'h00000000, 4'd3},          // R3
    '{1'b1, 12'h100, 32'h00001234, 32'h0, 4'd2},
    '{1'b0, 12'h100, 32'h0, 32'h00001234, 4'd2},          // R2
    '{1'b1, 12'h104, 32'h00000008, 32'h0, 4'd2},
    '{1'b0, 12'h104, 32'h0, 32'h00000008, 4'd2},          // R2
    '{1'b1, 12'h204, 32'hFFFFFFFF, 32'h0, 4'd6},
    '{1'b0, 12'h204, 32'h0, 32'h00000435, 4'd6},          // R6 R7
    '{1'b1, 12'h20C, 32'hA5A50F0F, 32'h0, 4'd12},
    '{1'b0, 12'h20C, 32'h0, 32'hA5A50F0F, 4'd12},         // R12
    '{1'b0, 12'h208, 32'h0, 32'h00000000, 4'd5},          // R5
    '{1'b1, 12'h200, 32'h0000FFFF, 32'h0, 4'd11},
    '{1'b0, 12'h200, 32'h0, 32'h00000101, 4'd11},         // R11
    '{1'b0, 12'h300, 32'h0, 32'h00000000, 4'd13},         // R13
    '{1'b1, 12'h228, 32'h00010001, 32'h0, 4'd10}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    bus_read("R1 tx base", 12'h000, 32'h0);
    bus_read("R1 cfg", 12'h204, 32'h0);
    bus_read("R1 status", 12'h220, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 outputs", {tx_en, rx_en, burst, multi}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_write(VEC[i].addr, VEC[i].data);
      else bus_read($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].addr, VEC[i].exp);
    end
    bus_read("R10 mask", 12'h228, 32'h00010001);
    check("R6 outputs", {tx_en, rx_en, burst, multi}, {27'b0, 1'b1, 1'b1, 2'b11, 1'b1});
    check("R12 dly out", dly_cfg, 32'hA5A50F0F);

    // R4 advance and wrap with TX count 5
    bus_write(12'h004, 32'd5);
    for (int k = 1; k <= 5; k++) begin
      pulse_tx_adv();
      bus_read("R4 tx advance", 12'h00C, 32'(k % 5));
    end
    // R5 clear overrides advance
    pulse_tx_adv(); pulse_tx_adv(); pulse_tx_adv();
    bus_read("R4 tx idx 3", 12'h00C, 32'd3);
    @(negedge clk);
    bus_we = 1; bus_addr = 12'h208; bus_wdata = 32'h00000001; tx_adv = 1;
    @(negedge clk);
    bus_we = 0; tx_adv = 0;
    bus_read("R5 tx clear wins", 12'h00C, 32'd0);
    // RX: advance twice, clear via bit 16, TX unaffected
    pulse_tx_adv();
    @(negedge clk); rx_adv = 1;
    @(negedge clk); @(negedge clk); rx_adv = 0;
    bus_read("R4 rx idx 2", 12'h10C, 32'd2);
    bus_write(12'h208, 32'h00010000);
    bus_read("R5 rx cleared", 12'h10C, 32'd0);
    bus_read("R5 tx kept", 12'h00C, 32'd1);
    // R4 zero count holds
    bus_write(12'h104, 32'd0);
    @(negedge clk); rx_adv = 1;
    @(negedge clk); @(negedge clk); rx_adv = 0;
    bus_read("R4 rx zero count", 12'h10C, 32'd0);

    // R7 busy gating
    tx_busy = 1;
    bus_read("R7 tx busy", 12'h204, 32'h00000437);
    bus_write(12'h204, 32'h00000004);
    rx_busy = 1;
    bus_read("R7 gated tx, rx busy", 12'h204, 32'h0000000C);
    tx_busy = 0; rx_busy = 0;

    // R8 R9 R10 status and irq
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
    bus_read("R8 tx done", 12'h220, 32'h00000001);
    check("R10 irq on", {31'b0, irq}, 32'h1);
    bus_write(12'h220, 32'h00000001);
    bus_read("R9 w1c", 12'h220, 32'h0);
    check("R10 irq off", {31'b0, irq}, 32'h0);
    @(negedge clk); dly_evt = 4'b0101;
    @(negedge clk); dly_evt = 4'b0;
    bus_read("R8 dly evt", 12'h220, 32'h50000000);
    check("R10 masked", {31'b0, irq}, 32'h0);
    @(negedge clk);
    bus_we = 1; bus_addr = 12'h220; bus_wdata = 32'h00010000; rx_done = 1;
    @(negedge clk);
    bus_we = 0; rx_done = 0;
    bus_read("R9 set wins", 12'h220, 32'h50010000);
    check("R10 irq rx", {31'b0, irq}, 32'h1);
    bus_write(12'h220, 32'hFFFFFFFF);
    bus_read("R9 clear all", 12'h220, 32'h0);
    check("R10 irq idle", {31'b0, irq}, 32'h0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule